// File: doc/BRIEF.md
# ROM-driven protocol microsequencer

This block is a small microcoded controller that steps through a byte-wide program store to sequence a link-layer protocol. Each instruction is two bytes: an opcode followed by an immediate. A single fast clock drives everything. An internal toggle flip-flop splits time into two phases, so the program counter advances once per fast cycle and an instruction completes once every two cycles. The opcode byte is always fetched in phase 0 and the immediate byte in phase 1. The instruction is decoded in the following phase 0 cycle, while the next opcode is fetched in that same cycle.

The opcode's top two bits select the instruction class:

- **Action (00):** pulses one control strobe.
- **Stall (01):** freezes the counter for a timed loop.
- **Jump (10):** reloads the counter from a target built from the opcode and immediate bytes.
- **Reserved (11):** does nothing.

An external reconfiguration timeout interrupts the sequencer at any point. It restarts the program from address 0 and sets a sticky status bit, which a host clears with a strobe. The program store is loaded through a write port that is only accepted while reset is held.

Top module: `useq_engine`

## Requirements
- R1: While `rst_n` is low, `pc_out`, `imm_out`, `ctl_strobe` and `recon_flag` are all 0, and `ld_we` writes `ld_data` into the store at `ld_addr`. When `rst_n` is high, `ld_we` has no effect on the store.
- R2: At the first clock edge after reset release, the opcode at address 0 is fetched. From then on, while fetching, `pc_out` advances by one on every fast clock edge. Opcode and immediate bytes alternate, opcode first.
- R3: An action opcode has bits [7:6] = 00. It takes effect only after both of its bytes are held. For exactly one fast cycle, which is the cycle after the immediate is captured, it drives `ctl_strobe` with a single bit set at index opcode[5:0]. If that index is NSTRB or more, no strobe is driven.
- R4: `imm_out` shows the immediate byte of the most recently fetched instruction, from the cycle its decode begins.
- R5: A jump opcode has bits [7:6] = 10. Its target is {opcode[1:0], immediate}. The next opcode is fetched from the target in the decode cycle, so `pc_out` becomes target+1 one edge later.
- R6: A jump target of WORDS (544) or above is replaced by address 0.
- R7: The program counter wraps from WORDS-1 to 0.
- R8: A stall opcode has bits [7:6] = 01. It freezes `pc_out` for N execute cycles (2N fast cycles), where N is the immediate, or 1 if the immediate is 0. Fetching then resumes.
- R9: `recon_timeout` high at an edge discards any partly fetched or pending instruction and sets `pc_out` to 0 after that edge. The opcode is then refetched from address 0 in phase 0. No strobe is driven while `recon_timeout` is high.
- R10: `recon_flag` is set by `recon_timeout` and stays set until `recon_clear`. When both are high at the same edge, the flag is set.
- R11: A reserved opcode has bits [7:6] = 11. It drives no strobe and leaves the fetch sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables program loading |
| recon_timeout | input | 1 | Reconfiguration timeout pulse, restarts the sequencer |
| recon_clear | input | 1 | Host strobe that clears `recon_flag` |
| ld_we | input | 1 | Program store write enable (honoured only in reset) |
| ld_addr | input | PCW | Program store write address |
| ld_data | input | 8 | Program store write data |
| ctl_strobe | output | NSTRB | Decoded one-cycle control strobes |
| imm_out | output | 8 | Immediate byte of the current instruction |
| pc_out | output | PCW | Current program counter |
| recon_flag | output | 1 | Sticky reconfiguration status |

## Verification
The assertions check the following on every cycle:

- the strobes are one-hot or zero and appear only in the decode phase;
- the counter never leaves the store;
- an immediate fetch always leads to a decode;
- the counter holds still during a stall;
- a timeout always leaves the counter at zero with the flag set;
- the flag stays set or clears as the two inputs dictate.

Some behaviour only the bench scenarios can show. These are the exact jump targets, including the replacement of out-of-range targets and the counter wrap. They also include the stall length measured in fast cycles, strobe decoding and immediate values against a known program, the restart sequence after a timeout, and store writes being ignored outside reset.

// File: rtl/useq_engine.sv
module useq_engine #(
  parameter int WORDS = 544,
  parameter int PCW   = 10,
  parameter int NSTRB = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recon_timeout,
  input  logic             recon_clear,
  input  logic             ld_we,
  input  logic [PCW-1:0]   ld_addr,
  input  logic [7:0]       ld_data,
  output logic [NSTRB-1:0] ctl_strobe,
  output logic [7:0]       imm_out,
  output logic [PCW-1:0]   pc_out,
  output logic             recon_flag
);
  localparam int SELW = $clog2(NSTRB);
  localparam int HIB  = PCW - 8;
  localparam logic [PCW-1:0] LAST = PCW'(WORDS - 1);

  logic [7:0]     mem [WORDS];
  logic [PCW-1:0] pc_q;
  logic [7:0]     op_q, imm_q, stall_q;
  logic           phase_q, have_op_q, exec_v_q;

  logic           is_act, is_nop, is_jmp, fetch_op;
  logic [PCW-1:0] tgt_raw, tgt, fetch_addr, pc_inc;
  logic [7:0]     rd;

  assign is_act     = exec_v_q && op_q[7:6] == 2'b00;
  assign is_nop     = exec_v_q && op_q[7:6] == 2'b01;
  assign is_jmp     = exec_v_q && op_q[7:6] == 2'b10;
  assign tgt_raw    = {op_q[HIB-1:0], imm_q};
  assign tgt        = (tgt_raw > LAST) ? '0 : tgt_raw;
  assign fetch_addr = is_jmp ? tgt : pc_q;
  assign pc_inc     = (fetch_addr == LAST) ? '0 : fetch_addr + 1'b1;
  assign fetch_op   = !phase_q && !is_nop && stall_q <= 8'd1;
  assign rd         = mem[fetch_addr];

  always_ff @(posedge clk) begin
    if (!rst_n && ld_we && ld_addr <= LAST)
      mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      op_q      <= '0;
      imm_q     <= '0;
      stall_q   <= '0;
      phase_q   <= 1'b0;
      have_op_q <= 1'b0;
      exec_v_q  <= 1'b0;
    end else if (recon_timeout) begin
      pc_q      <= '0;
      stall_q   <= '0;
      phase_q   <= 1'b0;
      have_op_q <= 1'b0;
      exec_v_q  <= 1'b0;
    end else begin
      phase_q <= !phase_q;
      if (!phase_q) begin
        exec_v_q <= 1'b0;
        if (is_nop)
          stall_q <= (imm_q == 8'd0) ? 8'd1 : imm_q;
        else if (stall_q != 8'd0)
          stall_q <= stall_q - 8'd1;
        if (fetch_op) begin
          op_q      <= rd;
          pc_q      <= pc_inc;
          have_op_q <= 1'b1;
        end
      end else if (have_op_q) begin
        imm_q     <= rd;
        pc_q      <= pc_inc;
        have_op_q <= 1'b0;
        exec_v_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             recon_flag <= 1'b0;
    else if (recon_timeout) recon_flag <= 1'b1;
    else if (recon_clear)   recon_flag <= 1'b0;
  end

  always_comb begin
    ctl_strobe = '0;
    if (is_act && !phase_q && !recon_timeout && op_q[5:0] < 6'(NSTRB))
      ctl_strobe[op_q[SELW-1:0]] = 1'b1;
  end

  assign imm_out = imm_q;
  assign pc_out  = pc_q;

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_strobe));
  // R3
  strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_strobe != '0) |-> (!phase_q && exec_v_q));
  // R7
  pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= LAST);
  // R2
  imm_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q && have_op_q && !recon_timeout) |=> (exec_v_q && !phase_q));
  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_q > 8'd1 || (stall_q != 8'd0 && phase_q)) && !recon_timeout)
      |=> pc_q == $past(pc_q));
  // R9
  recon_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recon_timeout |=> (pc_q == '0 && recon_flag && !exec_v_q && !have_op_q));
  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_flag && !recon_clear) |=> recon_flag);
  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_clear && !recon_timeout) |=> !recon_flag);
endmodule

// File: tb/useq_engine_bench.sv
module useq_engine_bench;
  localparam int WORDS = 544;
  localparam int PCW   = 10;
  localparam int NSTRB = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             recon_timeout = 1'b0;
  logic             recon_clear = 1'b0;
  logic             ld_we = 1'b0;
  logic [PCW-1:0]   ld_addr = '0;
  logic [7:0]       ld_data = '0;
  logic [NSTRB-1:0] ctl_strobe;
  logic [7:0]       imm_out;
  logic [PCW-1:0]   pc_out;
  logic             recon_flag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  useq_engine #(.WORDS(WORDS), .PCW(PCW), .NSTRB(NSTRB)) u_useq_engine (
    .clk(clk), .rst_n(rst_n), .recon_timeout(recon_timeout), .recon_clear(recon_clear),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .ctl_strobe(ctl_strobe), .imm_out(imm_out), .pc_out(pc_out), .recon_flag(recon_flag));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < WORDS; a++) begin
      ld_we = 1'b1; ld_addr = PCW'(a); ld_data = 8'hFF;
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    ld_we = 1'b1; ld_addr = PCW'(a); ld_data = d;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  task automatic t_sequence();
    enter_reset();
    wr(0, 8'h03); wr(1, 8'h5A); wr(2, 8'h00); wr(3, 8'h11); wr(4, 8'h08); wr(5, 8'h22);
    chk("R1 reset pc", pc_out, 0);
    chk("R1 reset strobe", ctl_strobe, 0);
    chk("R1 reset imm", imm_out, 0);
    release_reset();
    ld_we = 1'b1; ld_addr = 1; ld_data = 8'h00;
    adv(1);
    chk("R2 pc after first edge", pc_out, 1);
    chk("R3 no strobe before immediate", ctl_strobe, 0);
    adv(1);
    ld_we = 1'b0;
    chk("R2 pc after second edge", pc_out, 2);
    chk("R3 strobe index 3", ctl_strobe, 8'h08);
    chk("R1 write outside reset ignored", imm_out, 8'h5A);
    adv(1);
    chk("R3 strobe lasts one cycle", ctl_strobe, 0);
    chk("R2 pc step", pc_out, 3);
    adv(1);
    chk("R3 strobe index 0", ctl_strobe, 8'h01);
    chk("R4 imm second instr", imm_out, 8'h11);
    adv(2);
    chk("R3 index beyond NSTRB no strobe", ctl_strobe, 0);
    chk("R4 imm third instr", imm_out, 8'h22);
    chk("R2 pc third instr", pc_out, 6);
  endtask

  task automatic t_jump();
    enter_reset();
    wr(0, 8'h81); wr(1, 8'h04); wr(260, 8'h05); wr(261, 8'h77);
    release_reset();
    adv(2);
    chk("R5 jump gives no strobe", ctl_strobe, 0);
    adv(1);
    chk("R5 pc after jump fetch", pc_out, 261);
    adv(1);
    chk("R5 target strobe", ctl_strobe, 8'h20);
    chk("R5 target imm", imm_out, 8'h77);
    chk("R5 pc at target decode", pc_out, 262);
  endtask

  task automatic t_wrap();
    enter_reset();
    wr(0, 8'h82); wr(1, 8'h30);
    release_reset();
    adv(3);
    chk("R6 out of range target goes to 0", pc_out, 1);
    adv(1);
    chk("R6 refetched jump imm", imm_out, 8'h30);
    chk("R6 pc after refetch", pc_out, 2);
    enter_reset();
    wr(0, 8'h82); wr(1, 8'h1F); wr(543, 8'h02);
    release_reset();
    adv(3);
    chk("R7 pc wraps after last word", pc_out, 0);
    adv(1);
    chk("R7 strobe of instr spanning wrap", ctl_strobe, 8'h04);
    chk("R7 imm read from address 0", imm_out, 8'h82);
    chk("R7 pc after wrap", pc_out, 1);
  endtask

  task automatic t_stall(input logic [7:0] len, input logic [7:0] tag_imm);
    int n;
    n = (len == 0) ? 1 : int'(len);
    enter_reset();
    wr(0, 8'h40); wr(1, len); wr(2, 8'h01); wr(3, tag_imm);
    release_reset();
    adv(2);
    for (int i = 0; i < 2 * n; i++) begin
      adv(1);
      chk("R8 pc frozen during stall", pc_out, 2);
      chk("R8 no strobe during stall", ctl_strobe, 0);
    end
    adv(1);
    chk("R8 fetch resumes", pc_out, 3);
    adv(1);
    chk("R8 strobe after stall", ctl_strobe, 8'h02);
    chk("R8 imm after stall", imm_out, tag_imm);
  endtask

  task automatic t_recon();
    enter_reset();
    wr(0, 8'h00); wr(1, 8'h10); wr(2, 8'h01); wr(3, 8'h20);
    release_reset();
    adv(4);
    chk("R3 strobe before timeout", ctl_strobe, 8'h02);
    recon_timeout = 1'b1;
    #1;
    chk("R9 strobe masked by timeout", ctl_strobe, 0);
    adv(1);
    recon_timeout = 1'b0;
    chk("R9 pc cleared", pc_out, 0);
    chk("R10 flag set", recon_flag, 1);
    adv(1);
    chk("R9 refetch from 0", pc_out, 1);
    adv(1);
    chk("R9 first instr again", ctl_strobe, 8'h01);
    chk("R9 first imm again", imm_out, 8'h10);
    adv(1);
    recon_timeout = 1'b1;
    adv(1);
    recon_timeout = 1'b0;
    chk("R9 pc cleared mid fetch", pc_out, 0);
    adv(2);
    chk("R9 restart aligned to opcode", ctl_strobe, 8'h01);
    adv(5);
    chk("R10 flag sticky", recon_flag, 1);
    recon_clear = 1'b1;
    adv(1);
    recon_clear = 1'b0;
    chk("R10 flag cleared", recon_flag, 0);
    recon_clear = 1'b1; recon_timeout = 1'b1;
    adv(1);
    recon_clear = 1'b0; recon_timeout = 1'b0;
    chk("R10 timeout wins over clear", recon_flag, 1);
    enter_reset();
    chk("R1 reset clears flag", recon_flag, 0);
  endtask

  task automatic t_reserved();
    enter_reset();
    wr(0, 8'hC3); wr(1, 8'h12); wr(2, 8'h3F); wr(3, 8'h34); wr(4, 8'h07); wr(5, 8'h56);
    release_reset();
    adv(2);
    chk("R11 reserved no strobe", ctl_strobe, 0);
    chk("R11 reserved imm", imm_out, 8'h12);
    adv(1);
    chk("R11 fetch continues", pc_out, 3);
    adv(1);
    chk("R3 index 63 no strobe", ctl_strobe, 0);
    adv(2);
    chk("R3 strobe index 7", ctl_strobe, 8'h80);
    chk("R4 imm", imm_out, 8'h56);
    chk("R11 pc sequence", pc_out, 6);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    t_sequence();
    t_jump();
    t_wrap();
    t_stall(8'd3, 8'h99);
    t_stall(8'd0, 8'h44);
    t_recon();
    t_reserved();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule